// File: doc/BRIEF.md
# Credit-Gated Packet Transmit Scheduler

This block sits on the transmit side of a serial link and decides when a queued outgoing packet may go out. The receiver at the far end owns a set of receive buffers, one per traffic class. For each buffer the block keeps a cumulative credit limit granted by that receiver and a cumulative count of credits already spent. A packet of a given class and size, in credit units, is released only when spending its size keeps the spent count within the limit. Both counters are 12-bit wrapping values, and they are compared modulo 4096, so they never need to be cleared during operation.

At link bring-up the receiver advertises a starting amount for every class, which is loaded through the initialization port. After that, credit-return messages arrive on a separate update port. Each message carries a new cumulative limit for one class. A returned credit only raises the limit. There is no per-packet acknowledge, so the time credits take to come back never stalls traffic while enough credit remains.

Requests enter a small queue per class. A class whose oldest request lacks credit holds only its own later requests. The other classes continue to be served, with at most one grant per cycle.

Top module: `credit_tx_gate`

## Requirements
- R1: After reset `gnt_valid` is 0 and every bit of `req_ready` is 1. No grant is issued until every class has received an initialization load, and requests that arrive before that point are queued.
- R2: An `init_en` pulse for class `init_cls` sets that class's limit to `init_credit` and its spent count to 0, effective from the next cycle. If it coincides with an update or a grant for the same class, the initialization wins.
- R3: The oldest request of a class is eligible only if `(limit - (spent + size)) mod 4096 < 2048`. Each grant adds its size to the class's spent count, modulo 4096.
- R4: An update sets the class limit to `upd_limit` when `(upd_limit - limit) mod 4096 < 2048`. Any other update value is ignored, and the limit keeps its old value.
- R5: Within a class, requests are granted in the order they were accepted. A class whose oldest request is not eligible does not delay grants to other classes.
- R6: At most one grant is issued per cycle. When several classes are eligible, the lowest class number wins. `gnt_cls` and `gnt_size` then carry that class and the size of its oldest request.
- R7: Each class queue holds 4 requests. `req_ready[c]` is 0 while class c's queue is full, and a request offered to a full class is dropped.
- R8: The eligibility check and the spent count stay correct when the cumulative counts wrap past 4095.
- R9: While credit suffices, a class gets a grant on every cycle, without waiting for any update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_en | input | 1 | Load the starting credit for one class |
| init_cls | input | 2 | Class being initialized |
| init_credit | input | 12 | Advertised starting credit |
| upd_en | input | 1 | Credit-return message valid |
| upd_cls | input | 2 | Class of the credit-return message |
| upd_limit | input | 12 | New cumulative credit limit |
| req_valid | input | 1 | Packet request valid |
| req_cls | input | 2 | Packet class |
| req_size | input | 8 | Packet size in credit units |
| req_ready | output | 3 | Per-class queue has space |
| gnt_valid | output | 1 | A packet is released this cycle |
| gnt_cls | output | 2 | Class of the released packet |
| gnt_size | output | 8 | Size of the released packet |

## Verification
The assertions assume that the link partner never gives out more than 2047 credits of headroom per class. This means a starting credit below 2048, and limit minus spent count always below 2048. They also assume that class numbers stay below the class count. The sweeps keep starting credits small and raise a limit during random traffic only while the headroom is under 200. All other updates in random traffic deliberately carry values behind the current limit, so the ignore rule is exercised without ever breaking the headroom bound.

// File: rtl/cgate_pkg.sv
package cgate_pkg;

    localparam int CRED_W = 12;
    localparam int HALF   = 1 << (CRED_W - 1);

    typedef logic [CRED_W-1:0] credit_t;

    typedef struct packed {
        credit_t limit;
        credit_t used;
    } credit_state_t;

    // Room left after spending size: must stay in the lower half of the ring.
    function automatic logic credit_fits(credit_t limit, credit_t used, credit_t size);
        credit_t room;
        room = limit - (used + size);
        return ~room[CRED_W-1];
    endfunction

    // True when nxt is at or ahead of cur on the modular ring.
    function automatic logic credit_ahead(credit_t nxt, credit_t cur);
        credit_t delta;
        delta = nxt - cur;
        return ~delta[CRED_W-1];
    endfunction

endpackage

// File: rtl/cgate_class_fifo.sv
module cgate_class_fifo
    import cgate_pkg::*;
#(
    parameter int SIZE_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [SIZE_W-1:0] push_size,
    input  logic              pop,
    output logic              full,
    output logic              nonempty,
    output logic [SIZE_W-1:0] head_size
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [SIZE_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (count == CNT_W'(DEPTH));
    assign nonempty  = (count != '0);
    assign head_size = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_size;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    p_no_pop_empty_r5: assert property (@(posedge clk) disable iff (rst)
        pop |-> nonempty);

    p_full_refuses_r7: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full);

endmodule

// File: rtl/cgate_credit_ctr.sv
module cgate_credit_ctr
    import cgate_pkg::*;
#(
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_en,
    input  credit_t           init_val,
    input  logic              upd_en,
    input  credit_t           upd_val,
    input  logic              consume,
    input  logic [SIZE_W-1:0] head_size,
    output logic              fits,
    output logic              inited
);

    credit_state_t st_q;
    logic          inited_q;
    credit_t       head_cred;

    assign head_cred = credit_t'(head_size);
    assign fits      = inited_q & credit_fits(st_q.limit, st_q.used, head_cred);
    assign inited    = inited_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            inited_q <= 1'b0;
        end else if (init_en) begin
            st_q.limit <= init_val;
            st_q.used  <= '0;
            inited_q   <= 1'b1;
        end else begin
            if (upd_en && credit_ahead(upd_val, st_q.limit)) begin
                st_q.limit <= upd_val;
            end
            if (consume) begin
                st_q.used <= st_q.used + head_cred;
            end
        end
    end

    p_within_limit_r3: assert property (@(posedge clk) disable iff (rst)
        inited_q |-> ((st_q.limit - st_q.used) < credit_t'(HALF)));

    p_limit_no_regress_r4: assert property (@(posedge clk) disable iff (rst)
        (inited_q && !init_en) |=> ((st_q.limit - $past(st_q.limit)) < credit_t'(HALF)));

    p_init_clears_r2: assert property (@(posedge clk) disable iff (rst)
        init_en |=> (st_q.used == '0 && st_q.limit == $past(init_val) && inited_q));

endmodule

// File: rtl/cgate_pick.sv
module cgate_pick #(
    parameter int N     = 3,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     elig,
    output logic [N-1:0]     sel,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        logic found;
        found = 1'b0;
        sel   = '0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && !found) begin
                sel[i] = 1'b1;
                idx    = IDX_W'(i);
                found  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/credit_tx_gate.sv
module credit_tx_gate
    import cgate_pkg::*;
#(
    parameter int NUM_CLASS = 3,
    parameter int SIZE_W    = 8,
    parameter int QDEPTH    = 4,
    parameter int CLS_W     = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 init_en,
    input  logic [CLS_W-1:0]     init_cls,
    input  logic [CRED_W-1:0]    init_credit,
    input  logic                 upd_en,
    input  logic [CLS_W-1:0]     upd_cls,
    input  logic [CRED_W-1:0]    upd_limit,
    input  logic                 req_valid,
    input  logic [CLS_W-1:0]     req_cls,
    input  logic [SIZE_W-1:0]    req_size,
    output logic [NUM_CLASS-1:0] req_ready,
    output logic                 gnt_valid,
    output logic [CLS_W-1:0]     gnt_cls,
    output logic [SIZE_W-1:0]    gnt_size
);

    logic [NUM_CLASS-1:0] push_c, pop_c, full_c, ne_c, fit_c, inited_c;
    logic [NUM_CLASS-1:0] init_hit, upd_hit, elig;
    logic [SIZE_W-1:0]    head_sz [NUM_CLASS];
    logic                 all_init;

    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        assign push_c[c]   = req_valid & (req_cls == CLS_W'(c)) & ~full_c[c];
        assign init_hit[c] = init_en & (init_cls == CLS_W'(c));
        assign upd_hit[c]  = upd_en & (upd_cls == CLS_W'(c));

        cgate_class_fifo #(.SIZE_W(SIZE_W), .DEPTH(QDEPTH)) u_q (
            .clk       (clk),
            .rst       (rst),
            .push      (push_c[c]),
            .push_size (req_size),
            .pop       (pop_c[c]),
            .full      (full_c[c]),
            .nonempty  (ne_c[c]),
            .head_size (head_sz[c])
        );

        cgate_credit_ctr #(.SIZE_W(SIZE_W)) u_cr (
            .clk       (clk),
            .rst       (rst),
            .init_en   (init_hit[c]),
            .init_val  (init_credit),
            .upd_en    (upd_hit[c]),
            .upd_val   (upd_limit),
            .consume   (pop_c[c]),
            .head_size (head_sz[c]),
            .fits      (fit_c[c]),
            .inited    (inited_c[c])
        );
    end

    assign all_init  = &inited_c;
    assign elig      = ne_c & fit_c & {NUM_CLASS{all_init}};
    assign req_ready = ~full_c;

    cgate_pick #(.N(NUM_CLASS), .IDX_W(CLS_W)) u_pick (
        .elig (elig),
        .sel  (pop_c),
        .idx  (gnt_cls)
    );

    assign gnt_valid = |pop_c;

    always_comb begin
        gnt_size = '0;
        for (int c = 0; c < NUM_CLASS; c++) begin
            if (pop_c[c]) gnt_size = gnt_size | head_sz[c];
        end
    end

    p_grant_needs_init_r1: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> all_init);

    p_one_grant_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pop_c));

    p_grant_has_head_r5: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> ne_c[gnt_cls]);

endmodule

// File: tb/credit_tx_gate_tb_top.sv
module credit_tx_gate_tb_top;
    localparam int NC = 3;
    localparam int SW = 8;
    localparam int QD = 4;
    localparam int CW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          init_en = 0;
    logic [CW-1:0] init_cls = 0;
    logic [11:0]   init_credit = 0;
    logic          upd_en = 0;
    logic [CW-1:0] upd_cls = 0;
    logic [11:0]   upd_limit = 0;
    logic          req_valid = 0;
    logic [CW-1:0] req_cls = 0;
    logic [SW-1:0] req_size = 0;
    logic [NC-1:0] req_ready;
    logic          gnt_valid;
    logic [CW-1:0] gnt_cls;
    logic [SW-1:0] gnt_size;

    credit_tx_gate #(.NUM_CLASS(NC), .SIZE_W(SW), .QDEPTH(QD)) dut_i (
        .clk(clk), .rst(rst),
        .init_en(init_en), .init_cls(init_cls), .init_credit(init_credit),
        .upd_en(upd_en), .upd_cls(upd_cls), .upd_limit(upd_limit),
        .req_valid(req_valid), .req_cls(req_cls), .req_size(req_size),
        .req_ready(req_ready), .gnt_valid(gnt_valid), .gnt_cls(gnt_cls),
        .gnt_size(gnt_size)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R1";

    int mlim [NC];
    int mcons[NC];
    int minit[NC];
    int mq   [NC][QD];
    int mhd  [NC];
    int mcnt [NC];

    function automatic bit m_fits(int c);
        return ((mlim[c] - (mcons[c] + mq[c][mhd[c]])) & 4095) < 2048;
    endfunction

    function automatic int m_pick();
        if (!(minit[0] && minit[1] && minit[2])) return -1;
        for (int c = 0; c < NC; c++)
            if (mcnt[c] > 0 && m_fits(c)) return c;
        return -1;
    endfunction

    // Reference model advanced at each clock edge from the requirement rules.
    always @(posedge clk) begin
        int p;
        bit was_full;
        if (rst) begin
            for (int c = 0; c < NC; c++) begin
                mlim[c] = 0; mcons[c] = 0; minit[c] = 0; mhd[c] = 0; mcnt[c] = 0;
            end
        end else begin
            p = m_pick();
            was_full = (mcnt[req_cls] >= QD);
            if (p >= 0) begin
                mcons[p] = (mcons[p] + mq[p][mhd[p]]) & 4095;
                mhd[p]   = (mhd[p] + 1) % QD;
                mcnt[p]  = mcnt[p] - 1;
            end
            if (upd_en && (((int'(upd_limit) - mlim[upd_cls]) & 4095) < 2048))
                mlim[upd_cls] = upd_limit;
            if (init_en) begin
                mlim[init_cls] = init_credit; mcons[init_cls] = 0; minit[init_cls] = 1;
            end
            if (req_valid && !was_full) begin
                mq[req_cls][(mhd[req_cls] + mcnt[req_cls]) % QD] = req_size;
                mcnt[req_cls] = mcnt[req_cls] + 1;
            end
        end
    end

    task automatic check();
        int p;
        bit ev;
        p  = m_pick();
        ev = (p >= 0);
        n_chk++;
        if (gnt_valid !== ev ||
            (ev && (int'(gnt_cls) != p || int'(gnt_size) != mq[p][mhd[p]]))) begin
            n_bad++;
            $display("FAIL %s: grant v=%0b cls=%0d size=%0d, expected v=%0b cls=%0d size=%0d",
                     tag, gnt_valid, gnt_cls, gnt_size, ev, p, ev ? mq[p][mhd[p]] : 0);
        end
        for (int c = 0; c < NC; c++) begin
            n_chk++;
            if (req_ready[c] !== (mcnt[c] < QD)) begin
                n_bad++;
                $display("FAIL %s: req_ready[%0d]=%0b expected %0b", tag, c, req_ready[c], mcnt[c] < QD);
            end
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        check();
        init_en = 0; upd_en = 0; req_valid = 0;
    endtask

    task automatic do_init(int c, int v);
        init_en = 1; init_cls = CW'(c); init_credit = 12'(v); cyc();
    endtask

    task automatic do_upd(int c, int v);
        upd_en = 1; upd_cls = CW'(c); upd_limit = 12'(v); cyc();
    endtask

    task automatic do_req(int c, int s);
        req_valid = 1; req_cls = CW'(c); req_size = SW'(s); cyc();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state and no grants before every class is initialized
        tag = "R1";
        repeat (3) @(negedge clk);
        check();
        rst = 0;
        cyc();
        do_req(0, 1);
        do_req(1, 2);
        cyc();
        do_init(0, 10);
        do_init(1, 10);
        cyc();
        // R2: last class initialized, grants may now start
        tag = "R2";
        do_init(2, 10);
        repeat (4) cyc();

        // R3: sweep of starting credit against packet size on class 0
        tag = "R3";
        for (int cr = 0; cr <= 8; cr++) begin
            for (int s = 0; s <= 10; s++) begin
                do_init(0, cr);
                do_req(0, s);
                cyc();
                do_upd(0, cr + 20);
                cyc();
            end
        end

        // R4: updates behind the current limit are ignored
        tag = "R4";
        do_init(1, 5);
        do_req(1, 10);
        cyc();
        do_upd(1, 3);
        cyc();
        do_upd(1, (5 - 100) & 4095);
        cyc();
        do_upd(1, 10);
        cyc();
        cyc();

        // R5 R6: blocked class does not hold others; lowest class wins
        tag = "R5 R6";
        do_init(0, 0);
        do_init(1, 50);
        do_init(2, 50);
        req_valid = 1; req_cls = 0; req_size = 1; @(negedge clk); check();
        req_cls = 1; req_size = 3; @(negedge clk); check();
        req_cls = 2; req_size = 4; @(negedge clk); check();
        req_cls = 1; req_size = 2; @(negedge clk); check();
        req_valid = 0;
        repeat (4) cyc();
        do_upd(0, 1);
        cyc();

        // R7: queue fills, ready drops, extra requests are dropped
        tag = "R7";
        do_init(0, 0);
        for (int i = 0; i < 7; i++) do_req(0, i + 1);
        cyc();
        do_upd(0, 100);
        repeat (6) cyc();

        // R9: back-to-back grants without any update
        tag = "R9";
        do_init(2, 200);
        for (int i = 0; i < 12; i++) do_req(2, 5);
        repeat (4) cyc();

        // R8: cumulative counts wrap past 4095
        tag = "R8";
        do_init(2, 0);
        for (int i = 0; i < 30; i++) begin
            upd_en = 1; upd_cls = 2; upd_limit = 12'((mlim[2] + 200) & 4095);
            req_valid = 1; req_cls = 2; req_size = 200;
            cyc();
            cyc();
        end
        repeat (4) cyc();

        // R5 R6 R7 R8 R9: mixed random traffic on all classes
        tag = "R5 R6 R7 R8 R9";
        for (int i = 0; i < 4000; i++) begin
            int c;
            if (($urandom % 10) < 7) begin
                req_valid = 1; req_cls = CW'($urandom % NC); req_size = SW'($urandom % 16);
            end
            if (($urandom % 10) < 3) begin
                c = $urandom % NC;
                upd_en = 1; upd_cls = CW'(c);
                if (((mlim[c] - mcons[c]) & 4095) < 200)
                    upd_limit = 12'((mlim[c] + ($urandom % 40)) & 4095);
                else
                    upd_limit = 12'((mlim[c] - 1 - ($urandom % 8)) & 4095);
            end
            cyc();
        end
        repeat (8) cyc();

        finish_run();
    end
endmodule